// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block drives the channel multiplexer of a three-color analog front end. A host loads a bank of eight 9-bit registers through a parallel write port. The port carries a 3-bit address, 9-bit data and a write strobe. Two of these registers control sampling. The configuration word sets the channel mode and power-down. The multiplexer word sets the sampling order and the single-channel pick. The block decodes those two words and drives a one-hot select that chooses the color the front end samples next.

In three-channel mode the select steps through red, green and blue, in either direction, once per sample strobe. A line sync strobe sends it back to the first color of the current order. In single-channel mode the select stays on one programmed color. Power-down freezes the selector, and the bank still accepts writes and returns readback. Any register can be read back one cycle after its address is presented.

Top module: `color_sample_seq`

## Requirements
- R1: After reset, chan_sel_o is 3'b001 (red), pwr_dn_o is 0 and rdata_o is 0. Reading back gives configuration (address 0) = 9'h0F8, multiplexer (address 1) = 9'h0C0, and 0 at addresses 2 to 7.
- R2: rdata_o, sampled after a clock edge, equals the value that the register addressed by addr_i held before that edge. A write on that edge becomes visible on the following read.
- R3: Addresses 2, 3 and 4 keep only the low 6 bits of wdata_i and read back with bits 8:6 as zero. All other addresses keep all 9 bits.
- R4: When configuration bit 5 = 1, bit 2 = 0 and multiplexer bit 7 = 1, each edge with sample_i high and sync_i low moves chan_sel_o from red to green, from green to blue, and from blue back to red. chan_sel_o encodes red as bit 0, green as bit 1 and blue as bit 2.
- R5: With multiplexer bit 7 = 0 in three-channel mode, the same stepping runs blue, then green, then red, then back to blue.
- R6: In three-channel mode while not powered down, an edge with sync_i high selects the first color of the order after that edge: red when multiplexer bit 7 = 1 and blue when it is 0. This holds even if sample_i is high on the same edge.
- R7: With configuration bit 5 = 0, chan_sel_o follows multiplexer bits 6 (red), 5 (green) and 4 (blue), with priority red over green over blue. sample_i and sync_i do not change it.
- R8: In single-channel mode with multiplexer bits 6:4 all zero, chan_sel_o is 3'b000.
- R9: While configuration bit 2 = 1, pwr_dn_o is 1 and sample_i and sync_i leave the selector unchanged. Register writes and readback keep working. After power-down is cleared, stepping resumes from the held position.
- R10: chan_sel_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and readback |
| wdata_i | input | 9 | Write data |
| sample_i | input | 1 | Sample strobe, advances the selector |
| sync_i | input | 1 | Line sync strobe, returns the selector to the first color |
| chan_sel_o | output | 3 | One-hot channel select {blue, green, red} |
| pwr_dn_o | output | 1 | Power-down flag |
| rdata_o | output | 9 | Registered readback of the addressed register |

## Verification
The hardest cases are those where two events land on the same edge. One is a sync strobe on the same edge as a sample strobe. Another is a write to the configuration or multiplexer register on the edge where the selector would also step. A third is power-down that starts partway through a sequence and then ends. Directed phases cover the simultaneous sync and sample, the order flip partway through a sequence, and power-down that is entered and cleared again. A long phase then drives random strobes and random control-word writes on every edge. A behavioral model predicts the select, the flag and the readback on every cycle.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 9;
  localparam int GAIN_W   = 6;
  localparam int NUM_CH   = 3;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int POS_W    = $clog2(NUM_CH);

  localparam int ADR_CFG     = 0;
  localparam int ADR_MUX     = 1;
  localparam int ADR_GAIN_LO = 2;
  localparam int ADR_GAIN_HI = 4;

  localparam int CFG_MODE3 = 5;
  localparam int CFG_PD    = 2;
  localparam int MUX_ORDER = 7;
  localparam int MUX_RED   = 6;
  localparam int MUX_GRN   = 5;
  localparam int MUX_BLU   = 4;

  localparam logic [DATA_W-1:0] CFG_RST = 9'h0F8;
  localparam logic [DATA_W-1:0] MUX_RST = 9'h0C0;

  typedef struct packed {
    logic              mode3;
    logic              pwr_dn;
    logic              order_rgb;
    logic [NUM_CH-1:0] single_req;  // {blue, green, red}
  } ctrl_t;
endpackage

// File: rtl/cseq_regbank.sv
module cseq_regbank
  import cseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] mux_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == ADR_CFG) ? CFG_RST : (i == ADR_MUX) ? MUX_RST : '0;
    localparam bit IS_GAIN = (i >= ADR_GAIN_LO) && (i <= ADR_GAIN_HI);
    localparam logic [DATA_W-1:0] KEEP =
      IS_GAIN ? DATA_W'((1 << GAIN_W) - 1) : '1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[i] <= RST_VAL;
      else if (wr_en_i && addr_i == ADDR_W'(i))       regs_q[i] <= wdata_i & KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= regs_q[addr_i];
  end

  assign cfg_o = regs_q[ADR_CFG];
  assign mux_o = regs_q[ADR_MUX];
endmodule

// File: rtl/cseq_decode.sv
module cseq_decode
  import cseq_pkg::*;
(
  input  logic [DATA_W-1:0] cfg_i,
  input  logic [DATA_W-1:0] mux_i,
  output ctrl_t             ctrl_o
);
  always_comb begin
    ctrl_o.mode3      = cfg_i[CFG_MODE3];
    ctrl_o.pwr_dn     = cfg_i[CFG_PD];
    ctrl_o.order_rgb  = mux_i[MUX_ORDER];
    ctrl_o.single_req = {mux_i[MUX_BLU], mux_i[MUX_GRN], mux_i[MUX_RED]};
  end
endmodule

// File: rtl/cseq_selector.sv
module cseq_selector
  import cseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              sample_i,
  input  logic              sync_i,
  output logic [NUM_CH-1:0] chan_sel_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(NUM_CH - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] color;

  always_comb begin
    pos_d = pos_q;
    if (!ctrl_i.pwr_dn) begin
      if (sync_i)                       pos_d = '0;  // sync beats advance
      else if (sample_i && ctrl_i.mode3) pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  // position -> color index (0 red, 1 green, 2 blue)
  assign color = ctrl_i.order_rgb ? pos_q : LAST - pos_q;

  // single-channel: lowest set request wins (red > green > blue)
  logic [NUM_CH-1:0] single_sel;
  always_comb begin
    single_sel = '0;
    for (int k = NUM_CH - 1; k >= 0; k--)
      if (ctrl_i.single_req[k]) single_sel = NUM_CH'(1) << k;
  end

  always_comb begin
    if (ctrl_i.mode3) begin
      chan_sel_o = '0;
      for (int k = 0; k < NUM_CH; k++)
        if (color == POS_W'(k)) chan_sel_o[k] = 1'b1;
    end else begin
      chan_sel_o = single_sel;
    end
  end
endmodule

// File: rtl/color_sample_seq.sv
module color_sample_seq
  import cseq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [8:0]  wdata_i,
  input  logic        sample_i,
  input  logic        sync_i,
  output logic [2:0]  chan_sel_o,
  output logic        pwr_dn_o,
  output logic [8:0]  rdata_o
);
  logic [DATA_W-1:0] cfg, mux;
  ctrl_t             ctrl;

  cseq_regbank i_regbank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .mux_o   (mux),
    .rdata_o (rdata_o)
  );

  cseq_decode i_decode (
    .cfg_i  (cfg),
    .mux_i  (mux),
    .ctrl_o (ctrl)
  );

  cseq_selector i_selector (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .sample_i   (sample_i),
    .sync_i     (sync_i),
    .chan_sel_o (chan_sel_o)
  );

  assign pwr_dn_o = ctrl.pwr_dn;
endmodule

// File: rtl/color_sample_seq_chk.sv
module color_sample_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       sample_i,
  input logic       sync_i,
  input logic [2:0] chan_sel_o,
  input logic       pwr_dn_o,
  input logic       mode3_i,
  input logic       rgb_i
);
  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_sel_o));

  a_r4_rgb_red_to_green: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode3_i && !pwr_dn_o && rgb_i && sample_i && !sync_i && !wr_en_i && chan_sel_o == 3'b001
    |=> chan_sel_o == 3'b010);

  a_r5_bgr_red_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode3_i && !pwr_dn_o && !rgb_i && sample_i && !sync_i && !wr_en_i && chan_sel_o == 3'b001
    |=> chan_sel_o == 3'b100);

  a_r6_sync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode3_i && !pwr_dn_o && sync_i && !wr_en_i
    |=> chan_sel_o == (rgb_i ? 3'b001 : 3'b100));

  a_r7_single_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode3_i && !wr_en_i |=> $stable(chan_sel_o));

  a_r9_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o && !wr_en_i |=> $stable(chan_sel_o) && pwr_dn_o);
endmodule

bind color_sample_seq color_sample_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .sample_i   (sample_i),
  .sync_i     (sync_i),
  .chan_sel_o (chan_sel_o),
  .pwr_dn_o   (pwr_dn_o),
  .mode3_i    (ctrl.mode3),
  .rgb_i      (ctrl.order_rgb)
);

// File: tb/test_color_sample_seq.sv
module test_color_sample_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [8:0] wdata = '0;
  logic       sample = 1'b0;
  logic       sync = 1'b0;
  logic [2:0] chan_sel;
  logic       pwr_dn;
  logic [8:0] rdata;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  color_sample_seq i_color_sample_seq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .sample_i   (sample),
    .sync_i     (sync),
    .chan_sel_o (chan_sel),
    .pwr_dn_o   (pwr_dn),
    .rdata_o    (rdata)
  );

  // behavioural reference model
  logic [8:0] m_regs [8];
  int         m_pos;
  logic [8:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_regs[k]) m_regs[k] = 9'h000;
      m_regs[0] = 9'h0F8;
      m_regs[1] = 9'h0C0;
      m_pos     = 0;
      m_rdata   = 9'h000;
    end else begin
      m_rdata = m_regs[addr];
      if (!m_regs[0][2]) begin
        if (sync)                     m_pos = 0;
        else if (sample && m_regs[0][5]) m_pos = (m_pos + 1) % 3;
      end
      if (wr_en) m_regs[addr] = (addr >= 3'd2 && addr <= 3'd4) ? (wdata & 9'h03F) : wdata;
    end
  end

  function automatic logic [2:0] exp_sel();
    int c;
    if (m_regs[0][5]) begin
      c = m_regs[1][7] ? m_pos : 2 - m_pos;
      return 3'(1 << c);
    end
    if (m_regs[1][6]) return 3'b001;
    if (m_regs[1][5]) return 3'b010;
    if (m_regs[1][4]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic check(input int got, input int exp, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(chan_sel), int'(exp_sel()), "chan_sel");
      check(int'(pwr_dn), int'(m_regs[0][2]), "pwr_dn");
      check(int'(rdata), int'(m_rdata), "rdata");
    end
  end

  task automatic cyc(input logic w, input logic [2:0] a, input logic [8:0] d,
                     input logic s, input logic y);
    @(posedge clk);
    #1;
    wr_en = w; addr = a; wdata = d; sample = s; sync = y;
  endtask

  task automatic idle(input int n, input logic s);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 9'h000, s, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state seen directly on the ports
    check(int'(chan_sel), 1, "reset chan_sel");
    check(int'(pwr_dn), 0, "reset pwr_dn");
    check(int'(rdata), 0, "reset rdata");
    rst_n = 1'b1;

    cur_req = "R1";
    for (int a = 0; a < 8; a++) cyc(1'b0, 3'(a), 9'h000, 1'b0, 1'b0);
    idle(1, 1'b0);

    cur_req = "R2";
    cyc(1'b1, 3'd5, 9'h1AB, 1'b0, 1'b0);
    cyc(1'b1, 3'd7, 9'h155, 1'b0, 1'b0);
    cyc(1'b0, 3'd5, 9'h000, 1'b0, 1'b0);
    cyc(1'b0, 3'd7, 9'h000, 1'b0, 1'b0);
    cyc(1'b1, 3'd6, 9'h0AA, 1'b0, 1'b0);
    cyc(1'b0, 3'd6, 9'h000, 1'b0, 1'b0);

    cur_req = "R3";
    cyc(1'b1, 3'd2, 9'h1FF, 1'b0, 1'b0);
    cyc(1'b1, 3'd3, 9'h1C5, 1'b0, 1'b0);
    cyc(1'b1, 3'd4, 9'h0FF, 1'b0, 1'b0);
    for (int a = 2; a <= 4; a++) cyc(1'b0, 3'(a), 9'h000, 1'b0, 1'b0);
    idle(1, 1'b0);

    cur_req = "R4";
    idle(7, 1'b1);

    cur_req = "R6";
    idle(1, 1'b1);
    cyc(1'b0, 3'd0, 9'h000, 1'b0, 1'b1);
    idle(2, 1'b1);
    cyc(1'b0, 3'd0, 9'h000, 1'b1, 1'b1);
    idle(1, 1'b0);

    cur_req = "R5";
    cyc(1'b1, 3'd1, 9'h000, 1'b1, 1'b0);
    idle(5, 1'b1);
    cyc(1'b0, 3'd0, 9'h000, 1'b1, 1'b1);
    idle(2, 1'b1);

    cur_req = "R7";
    cyc(1'b1, 3'd0, 9'h0D8, 1'b0, 1'b0);
    cyc(1'b1, 3'd1, 9'h070, 1'b1, 1'b0);
    idle(3, 1'b1);
    cyc(1'b1, 3'd1, 9'h030, 1'b1, 1'b1);
    idle(3, 1'b1);
    cyc(1'b1, 3'd1, 9'h010, 1'b0, 1'b1);
    idle(3, 1'b1);
    cyc(1'b1, 3'd1, 9'h050, 1'b0, 1'b0);
    idle(2, 1'b1);

    cur_req = "R8";
    cyc(1'b1, 3'd1, 9'h080, 1'b1, 1'b0);
    idle(3, 1'b1);

    cur_req = "R9";
    cyc(1'b1, 3'd1, 9'h0C0, 1'b0, 1'b0);
    cyc(1'b1, 3'd0, 9'h0F8, 1'b0, 1'b0);
    idle(1, 1'b1);
    cyc(1'b1, 3'd0, 9'h0FC, 1'b1, 1'b0);
    idle(4, 1'b1);
    cyc(1'b0, 3'd0, 9'h000, 1'b1, 1'b1);
    cyc(1'b1, 3'd5, 9'h123, 1'b1, 1'b0);
    cyc(1'b0, 3'd5, 9'h000, 1'b1, 1'b0);
    cyc(1'b1, 3'd1, 9'h000, 1'b0, 1'b0);
    cyc(1'b1, 3'd1, 9'h0C0, 1'b0, 1'b0);
    cyc(1'b1, 3'd0, 9'h0F8, 1'b0, 1'b0);
    idle(4, 1'b1);

    cur_req = "R10";
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] a;
      logic [8:0] d;
      logic       w;
      a = 3'($urandom_range(0, 7));
      d = 9'($urandom);
      w = ($urandom_range(0, 9) == 0);
      if (a == 3'd0) d = {3'b011, d[5], 2'b10, d[2], 2'b00} | (d[0] ? 9'h004 : 9'h000) & 9'h0FC;
      cyc(w, a, d, 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    end
    idle(2, 1'b0);

    @(negedge clk);
    #1;
    finish_run();
  end
endmodule